// File: doc/BRIEF.md
# Indexed configuration port controller

This block is the configuration front end of a multi-function I/O controller. The host reaches it over a byte-wide I/O bus with a 16-bit address, write data, read data and single-cycle read and write strobes. Two consecutive I/O addresses form an index/data pair. Configuration access is locked until the host writes an entry key to the index port, and it is locked again by an exit key.

While the lock is open, the host writes a register index to the index port and then reads or writes the data port to reach that register. The register space has three parts:

- A logical-device number register.
- Two fixed identification bytes.
- A bank of per-device registers: activate, primary and secondary base address, and primary and secondary interrupt select. The bank is chosen by the logical-device number.

One auxiliary logical device also holds pin-configuration bytes for sixteen general-purpose pins.

The stored values drive per-device enable, base-address and interrupt outputs, and per-pin configuration outputs, to the rest of the chip.

Top module: `cfgp_ctrl`

## Requirements
- R1: After reset the block is in run (locked) state, the logical-device number is 0, and every `dev_en`, `dev_base`, `dev_irq` and pin-configuration output is 0.
- R2: A write of 0x55 to the index port (0x3F0) in run state opens configuration state. In run state, every other write to the index port or the data port (0x3F1) has no effect on any register.
- R3: A write of 0xAA to the index port in configuration state returns the block to run state. Data-port writes after that have no effect.
- R4: In configuration state, a write to the index port latches the index. A data-port write then updates the register at that index on the same clock edge. A data-port read returns that register's value combinationally, in the cycle `bus_rd` is high.
- R5: Any read while in run state returns 0xFF.
- R6: Index 0x07 is the 8-bit logical-device number, readable and writable.
- R7: Index 0x20 reads 0x30 and index 0x21 reads 0x01. Writes to either index have no effect.
- R8: Index 0x30 is activate. Bit 0 drives `dev_en[n]` for the selected device n, and the register reads back as {7'b0, bit0}.
- R9: Indices 0x60 (high byte) and 0x61 (low byte) form the primary base address, which appears on `dev_base[16n+15:16n]`. Indices 0x62 and 0x63 hold a secondary base address, high then low byte, that is readable back.
- R10: Index 0x70 stores bits 3:0 as the primary interrupt select, which appears on `dev_irq[4n+3:4n]`. Index 0x72 stores a secondary select. Both read back with bits 7:4 as zero.
- R11: A write while device n is selected changes only device n's registers and outputs.
- R12: With logical device 8 selected, indices 0xC0–0xC7 configure pins 0–7 and indices 0xE8–0xEF configure pins 8–15. In each byte, bit0 is direction (1 = input), bit1 is invert, bit2 is the combined-interrupt enable, and bits 4:3 are the function select. Bits 7:5 read as 0.
- R13: Unimplemented indices read 0x00 and ignore writes. This includes pin indices when the selected device is not 8, and per-device indices when the selected device is 9 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational |
| dev_en | output | 9 | Per-device enable |
| dev_base | output | 144 | Per-device 16-bit primary base address, device n at bits 16n+15:16n |
| dev_irq | output | 36 | Per-device 4-bit primary interrupt select |
| pin_dir | output | 16 | Per-pin direction, 1 = input |
| pin_inv | output | 16 | Per-pin invert |
| pin_irq_en | output | 16 | Per-pin combined-interrupt enable |
| pin_func | output | 32 | Per-pin 2-bit function select |

## Verification
The hardest situation to reach from the ports is a write that lands on a real index of the wrong bank. Examples are a pin-configuration index written while a device other than 8 is selected, and an activate write while an out-of-range device number is selected. In both cases the write must leave every output unchanged. The bench gets there by first programming known pin and enable values. It then re-points the logical-device register and repeats the same index writes. Finally it checks both the unchanged outputs and the zero read-back. Key handling is exercised the same way: register-shaped writes are issued in run state, and the untouched values are then inspected after re-entering configuration state.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam logic [7:0] KEY_ENTER    = 8'h55;
  localparam logic [7:0] KEY_EXIT     = 8'hAA;
  localparam logic [7:0] IX_LDN       = 8'h07;
  localparam logic [7:0] IX_ID        = 8'h20;
  localparam logic [7:0] IX_REV       = 8'h21;
  localparam logic [7:0] IX_ACT       = 8'h30;
  localparam logic [7:0] IX_PB_HI     = 8'h60;
  localparam logic [7:0] IX_PB_LO     = 8'h61;
  localparam logic [7:0] IX_SB_HI     = 8'h62;
  localparam logic [7:0] IX_SB_LO     = 8'h63;
  localparam logic [7:0] IX_PIRQ      = 8'h70;
  localparam logic [7:0] IX_SIRQ      = 8'h72;
  localparam logic [7:0] PIN_LO_BASE  = 8'hC0;
  localparam logic [7:0] PIN_HI_BASE  = 8'hE8;

  typedef enum logic {MODE_RUN = 1'b0, MODE_CFG = 1'b1} mode_e;
endpackage

// File: rtl/cfgp_rst_sync.sv
module cfgp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cfgp_mode.sv
module cfgp_mode
  import cfgp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_on,
  output logic [7:0] idx_q
);
  mode_e      mode_q, mode_d;
  logic [7:0] idx_d;

  always_comb begin
    mode_d = mode_q;
    idx_d  = idx_q;
    if (idx_wr) begin
      if (mode_q == MODE_RUN) begin
        if (wdata == KEY_ENTER) mode_d = MODE_CFG;
      end else if (wdata == KEY_EXIT) begin
        mode_d = MODE_RUN;
      end else begin
        idx_d = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      idx_q  <= 8'h00;
    end else if (idx_wr) begin
      mode_q <= mode_d;
      idx_q  <= idx_d;
    end
  end

  assign cfg_on = (mode_q == MODE_CFG);

  // R2
  enter_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !cfg_on && wdata == KEY_ENTER) |=> cfg_on);
  // R2
  run_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_on |=> $stable(idx_q));
  // R3
  exit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && cfg_on && wdata == KEY_EXIT) |=> !cfg_on);
endmodule

// File: rtl/cfgp_devbank.sv
module cfgp_devbank
  import cfgp_pkg::*;
#(
  parameter int NDEV = 9,
  parameter int BW   = 16,
  parameter int IW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       idx,
  input  logic [7:0]       wdata,
  input  logic [7:0]       ldn,
  output logic [7:0]       rd_val,
  output logic [NDEV-1:0]      dev_en,
  output logic [NDEV*BW-1:0]   dev_base,
  output logic [NDEV*IW-1:0]   dev_irq
);
  localparam int HB = BW / 2;

  logic [NDEV-1:0]         act_q,  act_d;
  logic [NDEV-1:0][BW-1:0] pb_q,   pb_d;
  logic [NDEV-1:0][BW-1:0] sb_q,   sb_d;
  logic [NDEV-1:0][IW-1:0] pi_q,   pi_d;
  logic [NDEV-1:0][IW-1:0] si_q,   si_d;
  logic [NDEV-1:0]         hit;

  always_comb begin
    act_d = act_q; pb_d = pb_q; sb_d = sb_q; pi_d = pi_q; si_d = si_q;
    for (int d = 0; d < NDEV; d++) begin
      hit[d] = (ldn == 8'(d));
      if (we && hit[d]) begin
        case (idx)
          IX_ACT:   act_d[d]        = wdata[0];
          IX_PB_HI: pb_d[d][BW-1:HB] = wdata;
          IX_PB_LO: pb_d[d][HB-1:0]  = wdata;
          IX_SB_HI: sb_d[d][BW-1:HB] = wdata;
          IX_SB_LO: sb_d[d][HB-1:0]  = wdata;
          IX_PIRQ:  pi_d[d]         = wdata[IW-1:0];
          IX_SIRQ:  si_d[d]         = wdata[IW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0; pb_q <= '0; sb_q <= '0; pi_q <= '0; si_q <= '0;
    end else if (we) begin
      act_q <= act_d; pb_q <= pb_d; sb_q <= sb_d; pi_q <= pi_d; si_q <= si_d;
    end
  end

  always_comb begin
    rd_val = 8'h00;
    for (int d = 0; d < NDEV; d++) begin
      if (hit[d]) begin
        case (idx)
          IX_ACT:   rd_val = {7'b0, act_q[d]};
          IX_PB_HI: rd_val = pb_q[d][BW-1:HB];
          IX_PB_LO: rd_val = pb_q[d][HB-1:0];
          IX_SB_HI: rd_val = sb_q[d][BW-1:HB];
          IX_SB_LO: rd_val = sb_q[d][HB-1:0];
          IX_PIRQ:  rd_val = 8'(pi_q[d]);
          IX_SIRQ:  rd_val = 8'(si_q[d]);
          default:  rd_val = 8'h00;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    assign dev_en[g]             = act_q[g];
    assign dev_base[g*BW +: BW]  = pb_q[g];
    assign dev_irq[g*IW +: IW]   = pi_q[g];

    // R11
    bank_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && ldn == 8'(g)) |=> ($stable(act_q[g]) && $stable(pb_q[g]) &&
                                 $stable(pi_q[g]) && $stable(sb_q[g]) && $stable(si_q[g])));
  end
endmodule

// File: rtl/cfgp_pins.sv
module cfgp_pins
  import cfgp_pkg::*;
#(
  parameter int NPIN    = 16,
  parameter int AUX_LDN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [7:0]        idx,
  input  logic [7:0]        wdata,
  input  logic [7:0]        ldn,
  output logic [7:0]        rd_val,
  output logic [NPIN-1:0]   pin_dir,
  output logic [NPIN-1:0]   pin_inv,
  output logic [NPIN-1:0]   pin_irq_en,
  output logic [2*NPIN-1:0] pin_func
);
  localparam int CW   = 5;
  localparam int HALF = 8;

  logic [NPIN-1:0][CW-1:0] cfg_q, cfg_d;
  logic                    aux_sel;

  function automatic logic [7:0] pin_index(input int k);
    if (k < HALF) return PIN_LO_BASE + 8'(k);
    else          return PIN_HI_BASE + 8'(k - HALF);
  endfunction

  assign aux_sel = (ldn == 8'(AUX_LDN));

  always_comb begin
    cfg_d  = cfg_q;
    rd_val = 8'h00;
    for (int k = 0; k < NPIN; k++) begin
      if (aux_sel && idx == pin_index(k)) begin
        rd_val = 8'(cfg_q[k]);
        if (we) cfg_d[k] = wdata[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= cfg_d;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign pin_dir[g]          = cfg_q[g][0];
    assign pin_inv[g]          = cfg_q[g][1];
    assign pin_irq_en[g]       = cfg_q[g][2];
    assign pin_func[2*g +: 2]  = cfg_q[g][4:3];
  end

  // R13
  pins_wrong_ldn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_sel |=> $stable(cfg_q));
  // R12
  pins_read_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_val[7:5] == 3'b000);
endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
  import cfgp_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [15:0] IDX_PORT = 16'h03F0,
  parameter logic [7:0]  CHIP_ID  = 8'h30,
  parameter logic [7:0]  CHIP_REV = 8'h01,
  parameter int          NDEV     = 9,
  parameter int          BW       = 16,
  parameter int          IW       = 4,
  parameter int          NPIN     = 16,
  parameter int          AUX_LDN  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        bus_addr,
  input  logic [7:0]           bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [7:0]           bus_rdata,
  output logic [NDEV-1:0]      dev_en,
  output logic [NDEV*BW-1:0]   dev_base,
  output logic [NDEV*IW-1:0]   dev_irq,
  output logic [NPIN-1:0]      pin_dir,
  output logic [NPIN-1:0]      pin_inv,
  output logic [NPIN-1:0]      pin_irq_en,
  output logic [2*NPIN-1:0]    pin_func
);
  localparam logic [AW-1:0] IDX_A = AW'(IDX_PORT);
  localparam logic [AW-1:0] DAT_A = AW'(IDX_PORT) + AW'(1);

  logic       rst_i_n;
  logic       at_idx, at_dat, idx_wr, dat_we, cfg_on;
  logic [7:0] idx_q, ldn_q, ldn_d, bank_rd, pin_rd, reg_val;

  cfgp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign at_idx = (bus_addr == IDX_A);
  assign at_dat = (bus_addr == DAT_A);
  assign idx_wr = bus_wr && at_idx;
  assign dat_we = bus_wr && at_dat && cfg_on;

  cfgp_mode u_mode (
    .clk(clk), .rst_n(rst_i_n), .idx_wr(idx_wr), .wdata(bus_wdata),
    .cfg_on(cfg_on), .idx_q(idx_q)
  );

  always_comb begin
    ldn_d = ldn_q;
    if (dat_we && idx_q == IX_LDN) ldn_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    ldn_q <= 8'h00;
    else if (dat_we) ldn_q <= ldn_d;
  end

  cfgp_devbank #(.NDEV(NDEV), .BW(BW), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .we(dat_we), .idx(idx_q), .wdata(bus_wdata),
    .ldn(ldn_q), .rd_val(bank_rd), .dev_en(dev_en), .dev_base(dev_base),
    .dev_irq(dev_irq)
  );

  cfgp_pins #(.NPIN(NPIN), .AUX_LDN(AUX_LDN)) u_pins (
    .clk(clk), .rst_n(rst_i_n), .we(dat_we), .idx(idx_q), .wdata(bus_wdata),
    .ldn(ldn_q), .rd_val(pin_rd), .pin_dir(pin_dir), .pin_inv(pin_inv),
    .pin_irq_en(pin_irq_en), .pin_func(pin_func)
  );

  always_comb begin
    case (idx_q)
      IX_LDN:  reg_val = ldn_q;
      IX_ID:   reg_val = CHIP_ID;
      IX_REV:  reg_val = CHIP_REV;
      default: reg_val = bank_rd | pin_rd;
    endcase
  end

  assign bus_rdata = (bus_rd && at_dat && cfg_on) ? reg_val : 8'hFF;

  // R5
  run_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_rd && !cfg_on) |-> bus_rdata == 8'hFF);
  // R7
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_rd && at_dat && cfg_on && idx_q == IX_ID) |-> bus_rdata == CHIP_ID);
  // R6
  ldn_run_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !cfg_on |=> $stable(ldn_q));
endmodule

// File: tb/cfgp_ctrl_test.sv
module cfgp_ctrl_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  bus_addr;
  logic [7:0]   bus_wdata;
  logic         bus_wr, bus_rd;
  logic [7:0]   bus_rdata;
  logic [8:0]   dev_en;
  logic [143:0] dev_base;
  logic [35:0]  dev_irq;
  logic [15:0]  pin_dir, pin_inv, pin_irq_en;
  logic [31:0]  pin_func;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [15:0] IP = 16'h03F0;
  localparam logic [15:0] DP = 16'h03F1;

  always #4 clk = ~clk;

  cfgp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .dev_en(dev_en),
    .dev_base(dev_base), .dev_irq(dev_irq), .pin_dir(pin_dir), .pin_inv(pin_inv),
    .pin_irq_en(pin_irq_en), .pin_func(pin_func)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic cfg_wr(input logic [7:0] ix, input logic [7:0] v);
    io_wr(IP, ix);
    io_wr(DP, v);
  endtask

  task automatic cfg_rd(input logic [7:0] ix, output logic [7:0] v);
    io_wr(IP, ix);
    io_rd(DP, v);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 dev_en", 32'(dev_en), 0);
    chk("R1 dev_base", 32'(|dev_base), 0);
    chk("R1 dev_irq", 32'(dev_irq), 0);
    chk("R1 pins", {pin_dir, pin_inv} | pin_func | 32'(pin_irq_en), 0);
    io_rd(DP, v);
    chk("R5 run read", 32'(v), 32'hFF);
  endtask

  task automatic t_run_ignored;
    logic [7:0] v;
    io_wr(IP, 8'h07); io_wr(DP, 8'h04);
    io_wr(IP, 8'h30); io_wr(DP, 8'h01);
    chk("R2 run writes ignored", 32'(dev_en), 0);
    io_rd(IP, v);
    chk("R5 run index read", 32'(v), 32'hFF);
    io_wr(IP, 8'h55);
    cfg_rd(8'h07, v);
    chk("R2 ldn untouched", 32'(v), 0);
  endtask

  task automatic t_ldn_exit;
    logic [7:0] v;
    cfg_wr(8'h07, 8'h05);
    cfg_rd(8'h07, v);
    chk("R6 ldn readback", 32'(v), 5);
    io_wr(IP, 8'hAA);
    io_rd(DP, v);
    chk("R3 after exit read", 32'(v), 32'hFF);
    io_wr(DP, 8'h02);
    io_wr(IP, 8'h30); io_wr(DP, 8'h01);
    chk("R3 after exit no activate", 32'(dev_en), 0);
    io_wr(IP, 8'h55);
    cfg_rd(8'h07, v);
    chk("R3 ldn kept", 32'(v), 5);
  endtask

  task automatic t_ids;
    logic [7:0] v;
    cfg_rd(8'h20, v); chk("R7 id", 32'(v), 32'h30);
    cfg_rd(8'h21, v); chk("R7 rev", 32'(v), 32'h01);
    cfg_wr(8'h20, 8'hFF);
    cfg_rd(8'h20, v); chk("R7 id read-only", 32'(v), 32'h30);
  endtask

  task automatic t_activate;
    logic [7:0] v;
    cfg_wr(8'h07, 8'h04);
    cfg_wr(8'h30, 8'h01);
    chk("R8 enable set", 32'(dev_en), 32'h010);
    cfg_rd(8'h30, v); chk("R4 R8 readback", 32'(v), 1);
    cfg_wr(8'h30, 8'hFE);
    chk("R8 bit0 only", 32'(dev_en), 0);
    cfg_rd(8'h30, v); chk("R8 readback zero", 32'(v), 0);
    cfg_wr(8'h30, 8'h01);
  endtask

  task automatic t_base_irq;
    logic [7:0] v;
    cfg_wr(8'h60, 8'h03); cfg_wr(8'h61, 8'hF8);
    chk("R9 primary base", 32'(dev_base[64 +: 16]), 32'h03F8);
    cfg_wr(8'h62, 8'h12); cfg_wr(8'h63, 8'h34);
    cfg_rd(8'h62, v); chk("R9 secondary hi", 32'(v), 32'h12);
    cfg_rd(8'h63, v); chk("R9 secondary lo", 32'(v), 32'h34);
    cfg_wr(8'h70, 8'h34);
    chk("R10 primary irq", 32'(dev_irq[16 +: 4]), 4);
    cfg_rd(8'h70, v); chk("R10 primary readback", 32'(v), 4);
    cfg_wr(8'h72, 8'hFB);
    cfg_rd(8'h72, v); chk("R10 secondary readback", 32'(v), 32'h0B);
  endtask

  task automatic t_banking;
    logic [7:0] v;
    cfg_wr(8'h07, 8'h05);
    cfg_wr(8'h60, 8'h02); cfg_wr(8'h61, 8'hF8);
    chk("R11 dev5 base", 32'(dev_base[80 +: 16]), 32'h02F8);
    chk("R11 dev4 base kept", 32'(dev_base[64 +: 16]), 32'h03F8);
    cfg_rd(8'h70, v); chk("R11 dev5 irq empty", 32'(v), 0);
    cfg_wr(8'h07, 8'h07);
    cfg_wr(8'h30, 8'h01);
    chk("R11 enables", 32'(dev_en), 32'h090);
  endtask

  task automatic t_pins;
    logic [7:0] v;
    cfg_wr(8'h07, 8'h08);
    cfg_wr(8'hC5, 8'h01);
    cfg_wr(8'hC6, 8'h1E);
    cfg_wr(8'hEA, 8'hFF);
    cfg_wr(8'hE8, 8'h08);
    chk("R12 dir", 32'(pin_dir), 32'h0420);
    chk("R12 inv", 32'(pin_inv), 32'h0440);
    chk("R12 irq_en", 32'(pin_irq_en), 32'h0440);
    chk("R12 func", pin_func, 32'h0031_3000);
    cfg_rd(8'hEA, v); chk("R12 upper bits zero", 32'(v), 32'h1F);
  endtask

  task automatic t_unimpl;
    logic [7:0] v;
    cfg_wr(8'h40, 8'h5A);
    cfg_rd(8'h40, v); chk("R13 unimpl read", 32'(v), 0);
    cfg_wr(8'h07, 8'h03);
    cfg_wr(8'hC5, 8'h00);
    chk("R13 pin write wrong ldn", 32'(pin_dir), 32'h0420);
    cfg_rd(8'hC5, v); chk("R13 pin read wrong ldn", 32'(v), 0);
    cfg_wr(8'h07, 8'h09);
    cfg_wr(8'h30, 8'h01);
    chk("R13 ldn out of range", 32'(dev_en), 32'h090);
    cfg_rd(8'h30, v); chk("R13 out of range read", 32'(v), 0);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_run_ignored;
    t_ldn_exit;
    t_ids;
    t_activate;
    t_base_irq;
    t_banking;
    t_pins;
    t_unimpl;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule